// File: doc/BRIEF.md
# Randomized Single-Byte Memory Request Generator

This block is a traffic source for stress-testing a memory subsystem. It emits a stream of one-byte read and write requests on a valid/ready request port. The command, the write data, the region choice and the address offset all come from a free-running linear feedback shift register. Each tester instance gets its own seed and its own tester id. The id is placed in the low bits of every address, so several instances that share a memory hit the same cache blocks at different byte lanes.

Three address windows exist. Two of them are cacheable and sit at 0x100000 and 0x400000. The third is flagged uncacheable and sits at 0x800000. A table of in-flight addresses keeps the generator from issuing to an address that has not yet completed; a drawn address that hits the table is thrown away and a new one is drawn on the next cycle. The table is released entry by entry through a completion input that carries the finished address. A refused request is held unchanged until the port takes it. After acceptance, a pacing timer delays the next issue. A stall watchdog and an overflow flag report a port that takes nothing for too long and a table that holds more entries than allowed.

Top module: `rand_req_gen`

## Requirements
- R1: While reset is asserted, `req_valid`, `err_stall` and `err_overflow` are 0. The first request is presented one clock edge after reset is released.
- R2: The low log2(BLK_BYTES) bits of every request address equal TESTER_ID. Bits 19 down to log2(REGION_BYTES) of the address are zero.
- R3: Address bits 23:20 are 0x8 exactly when `req_uncache` is 1. Otherwise they are 0x1 or 0x4. An uncacheable request is drawn when a random value from 0 to 100 is below UNC_PCT, so UNC_PCT = 0 never yields one.
- R4: A request is a read (`req_write` = 0) when a random value from 0 to 100 is below RD_PCT. RD_PCT = 101 gives only reads, and a mid value gives both reads and writes.
- R5: While `req_valid` is 1 and `req_ready` is 0, the next cycle still has `req_valid` = 1, with address, data, command and uncacheable flag unchanged.
- R6: After a request is accepted at an edge, `req_valid` is not seen high again until at least INTERVAL edges later.
- R7: No request carries an address that has been accepted and not yet completed. Once every reachable address is outstanding, no further request is issued.
- R8: A pulse on `cpl_valid` with `cpl_addr` frees that address, and the address can be issued again.
- R9: `err_stall` becomes 1 at the CHECK_CYCLES-th edge after the last acceptance (or after reset) when no acceptance occurs in between. It then stays 1 until reset.
- R10: `err_overflow` becomes 1 one edge after the number of outstanding addresses first exceeds MAX_OUT. It then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | output | 1 | A request is presented |
| req_ready | input | 1 | The memory port accepts the request at this edge |
| req_addr | output | 24 | Byte address of the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_data | output | 8 | Write data (random) |
| req_uncache | output | 1 | Request targets the uncacheable window |
| cpl_valid | input | 1 | A request has completed |
| cpl_addr | input | 24 | Address of the completed request |
| err_stall | output | 1 | Sticky: no acceptance for CHECK_CYCLES edges |
| err_overflow | output | 1 | Sticky: outstanding count exceeded MAX_OUT |

## Verification
The in-flight table check assumes that `cpl_addr` names an address that is currently outstanding, and that at most one completion arrives per cycle. The bench only completes addresses it has itself recorded as accepted, with one single-cycle pulse each. The hold-stability property assumes the port never withdraws `req_ready` in the same cycle it accepts. The bench drives ready on the falling edge and lowers it right after each acceptance. A second instance is given a region so small that only eight addresses are reachable. This makes table exhaustion and release visible at the port.

// File: rtl/mrg_pkg.sv
package mrg_pkg;

   localparam int ADDR_W = 24;
   localparam int FLD_LSB = 23;  // first random bit used for the block select

   localparam logic [ADDR_W-1:0] WIN_A   = 24'h100000;
   localparam logic [ADDR_W-1:0] WIN_B   = 24'h400000;
   localparam logic [ADDR_W-1:0] WIN_UNC = 24'h800000;

   typedef struct packed {
      logic [ADDR_W-1:0] addr;
      logic [7:0]        data;
      logic              wr;
      logic              unc;
   } mreq_t;

   // fold a 7-bit random value into the range 0..100
   function automatic logic [6:0] pct_fold(input logic [6:0] v);
      return (v >= 7'd101) ? (v - 7'd101) : v;
   endfunction

endpackage

// File: rtl/mrg_lfsr.sv
module mrg_lfsr #(
   parameter int          W     = 64,
   parameter logic [63:0] SEED  = 64'h1,
   parameter int          OUT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   output logic [OUT_W-1:0] rnd
);

   logic [W-1:0] taps;
   logic [W-1:0] st_q;

   generate
      if (W == 64) begin : g_w64
         assign taps = 64'hD800_0000_0000_0000;
      end else if (W == 32) begin : g_w32
         assign taps = 32'h8020_0003;
      end else begin : g_bad
         $error("mrg_lfsr: W must be 32 or 64");
         assign taps = '0;
      end
      if (OUT_W > W) begin : g_chk_out
         $error("mrg_lfsr: OUT_W exceeds W");
      end
      if (SEED[W-1:0] == '0) begin : g_chk_seed
         $error("mrg_lfsr: seed must be non-zero");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= SEED[W-1:0];
      else        st_q <= (st_q >> 1) ^ (st_q[0] ? taps : '0);
   end

   assign rnd = st_q[OUT_W-1:0];

endmodule

// File: rtl/mrg_cam.sv
module mrg_cam
   import mrg_pkg::*;
#(
   parameter int DEPTH = 128,
   localparam int OCC_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] look_addr,
   output logic              look_hit,
   input  logic              ins_en,
   input  logic [ADDR_W-1:0] ins_addr,
   input  logic              clr_en,
   input  logic [ADDR_W-1:0] clr_addr,
   output logic [OCC_W-1:0]  occ
);

   logic [DEPTH-1:0]  vld_q;
   logic [ADDR_W-1:0] tag_q [DEPTH];
   logic [DEPTH-1:0]  look_m, clr_m, ins_m, free_oh;

   generate
      for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
         assign look_m[i] = vld_q[i] && (tag_q[i] == look_addr);
         assign clr_m[i]  = vld_q[i] && (tag_q[i] == clr_addr);
         assign ins_m[i]  = vld_q[i] && (tag_q[i] == ins_addr);
      end
   endgenerate

   always_comb begin
      logic found;
      found   = 1'b0;
      free_oh = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (!vld_q[i] && !found) begin
            free_oh[i] = 1'b1;
            found      = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         for (int i = 0; i < DEPTH; i++) begin
            if (ins_en && free_oh[i])      vld_q[i] <= 1'b1;
            else if (clr_en && clr_m[i])   vld_q[i] <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < DEPTH; i++) begin
         if (ins_en && free_oh[i]) tag_q[i] <= ins_addr;
      end
   end

   assign look_hit = |look_m;
   assign occ      = OCC_W'($countones(vld_q));

   // R7: an address being recorded must not already be in flight
   p_no_dup_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> !(|ins_m));

   // R7: an insertion always finds a free slot
   p_slot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ins_en |-> $onehot0(free_oh) && (|free_oh));

endmodule

// File: rtl/mrg_watch.sv
module mrg_watch #(
   parameter int CHECK = 5000,
   localparam int CW = $clog2(CHECK)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic kick,
   output logic err
);

   logic [CW-1:0] cnt_q;
   logic          err_q;

   generate
      if (CHECK < 2) begin : g_chk
         $error("mrg_watch: CHECK must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         err_q <= 1'b0;
      end else begin
         if (kick)                              cnt_q <= '0;
         else if (cnt_q != CW'(CHECK - 1))      cnt_q <= cnt_q + CW'(1);
         if (!kick && cnt_q == CW'(CHECK - 1))  err_q <= 1'b1;
      end
   end

   assign err = err_q;

   // R9: the stall flag is sticky
   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);

   // R9: a kick in the previous cycle means the count restarted
   p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> cnt_q == '0);

endmodule

// File: rtl/rand_req_gen.sv
module rand_req_gen
   import mrg_pkg::*;
#(
   parameter int          TESTER_ID    = 0,
   parameter int          BLK_BYTES    = 64,
   parameter int          REGION_BYTES = 4096,
   parameter int          RD_PCT       = 65,
   parameter int          UNC_PCT      = 10,
   parameter int          INTERVAL     = 1,
   parameter int          CHECK_CYCLES = 5000,
   parameter int          MAX_OUT      = 100,
   parameter int          CAM_DEPTH    = 128,
   parameter int          RNG_W        = 64,
   parameter logic [63:0] SEED         = 64'h0123_4567_89AB_CDEF
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   output logic              req_write,
   output logic [7:0]        req_data,
   output logic              req_uncache,
   input  logic              cpl_valid,
   input  logic [ADDR_W-1:0] cpl_addr,
   output logic              err_stall,
   output logic              err_overflow
);

   localparam int BLK_W = $clog2(BLK_BYTES);
   localparam int OFF_W = $clog2(REGION_BYTES);
   localparam int SEL_W = OFF_W - BLK_W;
   localparam int RND_W = FLD_LSB + SEL_W;
   localparam int WT_W  = $clog2(INTERVAL + 1);
   localparam int OCC_W = $clog2(CAM_DEPTH + 1);
   localparam logic [BLK_W-1:0] ID_BITS = BLK_W'(TESTER_ID);
   localparam logic [7:0]       RD_TH   = 8'(RD_PCT);
   localparam logic [7:0]       UNC_TH  = 8'(UNC_PCT);

   generate
      if (BLK_BYTES < 2 || (1 << BLK_W) != BLK_BYTES) begin : g_e_blk
         $error("rand_req_gen: BLK_BYTES must be a power of two >= 2");
      end
      if ((1 << OFF_W) != REGION_BYTES || REGION_BYTES <= BLK_BYTES
          || REGION_BYTES > (1 << 20)) begin : g_e_reg
         $error("rand_req_gen: REGION_BYTES must be a power of two in (BLK_BYTES, 1M]");
      end
      if (TESTER_ID < 0 || TESTER_ID >= BLK_BYTES) begin : g_e_id
         $error("rand_req_gen: TESTER_ID must be below BLK_BYTES");
      end
      if (RD_PCT < 0 || RD_PCT > 101 || UNC_PCT < 0 || UNC_PCT > 101) begin : g_e_pct
         $error("rand_req_gen: percentages must lie in 0..101");
      end
      if (INTERVAL < 1) begin : g_e_int
         $error("rand_req_gen: INTERVAL must be at least 1");
      end
      if (MAX_OUT < 1 || MAX_OUT >= CAM_DEPTH) begin : g_e_max
         $error("rand_req_gen: MAX_OUT must be below CAM_DEPTH");
      end
      if (RND_W > RNG_W) begin : g_e_rng
         $error("rand_req_gen: random source too narrow for the region");
      end
   endgenerate

   // ---------------- random source and candidate request ----------------
   logic [RND_W-1:0] rnd;

   mrg_lfsr #(.W(RNG_W), .SEED(SEED), .OUT_W(RND_W)) u_rng (
      .clk   (clk),
      .rst_n (rst_n),
      .rnd   (rnd)
   );

   mreq_t             cand;
   logic [6:0]        cmd_draw, unc_draw;
   logic [ADDR_W-1:0] cand_base;

   always_comb begin
      cmd_draw  = pct_fold(rnd[6:0]);
      unc_draw  = pct_fold(rnd[13:7]);
      cand.unc  = ({1'b0, unc_draw} < UNC_TH);
      cand.wr   = !({1'b0, cmd_draw} < RD_TH);
      cand.data = rnd[22:15];
      cand_base = cand.unc ? WIN_UNC : (rnd[14] ? WIN_A : WIN_B);
      cand.addr = cand_base | {{(ADDR_W-OFF_W){1'b0}}, rnd[RND_W-1:FLD_LSB], ID_BITS};
   end

   // ---------------- in-flight table ----------------
   logic             cand_hit;
   logic [OCC_W-1:0] occ;
   logic             busy_q, acc, tbl_full;
   mreq_t            req_q;

   assign acc = busy_q && req_ready;

   mrg_cam #(.DEPTH(CAM_DEPTH)) u_tbl (
      .clk       (clk),
      .rst_n     (rst_n),
      .look_addr (cand.addr),
      .look_hit  (cand_hit),
      .ins_en    (acc),
      .ins_addr  (req_q.addr),
      .clr_en    (cpl_valid),
      .clr_addr  (cpl_addr),
      .occ       (occ)
   );

   assign tbl_full = (occ == OCC_W'(CAM_DEPTH));

   // ---------------- issue pacing and request holding ----------------
   logic [WT_W-1:0] wait_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         wait_q <= '0;
      end else if (busy_q) begin
         if (req_ready) begin
            busy_q <= 1'b0;
            wait_q <= WT_W'(INTERVAL - 1);
         end
      end else if (wait_q != '0) begin
         wait_q <= wait_q - WT_W'(1);
      end else if (!cand_hit && !tbl_full) begin
         busy_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!busy_q && wait_q == '0 && !cand_hit && !tbl_full) req_q <= cand;
   end

   assign req_valid   = busy_q;
   assign req_addr    = req_q.addr;
   assign req_write   = req_q.wr;
   assign req_data    = req_q.data;
   assign req_uncache = req_q.unc;

   // ---------------- stall watchdog and overflow flag ----------------
   mrg_watch #(.CHECK(CHECK_CYCLES)) u_wd (
      .clk   (clk),
      .rst_n (rst_n),
      .kick  (acc),
      .err   (err_stall)
   );

   logic ovf_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                        ovf_q <= 1'b0;
      else if (occ > OCC_W'(MAX_OUT))    ovf_q <= 1'b1;
   end
   assign err_overflow = ovf_q;

   // ---------------- assertions ----------------
   p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_data)
                                  && $stable(req_write) && $stable(req_uncache));

   p_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && req_ready |=> !req_valid);

   p_win_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |-> (req_uncache == (req_addr[23:20] == 4'h8)));

   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_overflow |=> err_overflow);

endmodule

// File: tb/sim_rand_req_gen.sv
`timescale 1ns/1ps
module sim_rand_req_gen;

   localparam int I0 = 3;
   localparam int C0 = 40;
   localparam int M0 = 6;
   localparam int NV = 16;
   // each vector: {ready-low hold cycles [4:1], complete right after acceptance [0]}
   localparam logic [4:0] VEC [NV] = '{
      5'b0000_1, 5'b0011_1, 5'b0000_0, 5'b0101_1,
      5'b0001_1, 5'b1000_1, 5'b0000_1, 5'b0010_0,
      5'b0000_1, 5'b0111_1, 5'b0001_1, 5'b0000_1,
      5'b0100_0, 5'b0000_1, 5'b0010_1, 5'b0001_1
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   int unsigned cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   logic        r0 = 1'b0, cv0 = 1'b0;
   logic [23:0] ca0 = '0;
   logic        v0, w0, uc0, es0, eo0;
   logic [23:0] a0;
   logic [7:0]  d0;

   logic        cv1 = 1'b0;
   logic [23:0] ca1 = '0;
   logic        v1, w1, uc1, es1, eo1;
   logic [23:0] a1;
   logic [7:0]  d1;

   rand_req_gen #(.TESTER_ID(5), .BLK_BYTES(64), .REGION_BYTES(4096), .RD_PCT(50),
                  .UNC_PCT(25), .INTERVAL(I0), .CHECK_CYCLES(C0), .MAX_OUT(M0),
                  .SEED(64'h0000_BEEF_1234_5671)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(v0), .req_ready(r0), .req_addr(a0),
      .req_write(w0), .req_data(d0), .req_uncache(uc0), .cpl_valid(cv0),
      .cpl_addr(ca0), .err_stall(es0), .err_overflow(eo0));

   rand_req_gen #(.TESTER_ID(3), .BLK_BYTES(4), .REGION_BYTES(16), .RD_PCT(101),
                  .UNC_PCT(0), .INTERVAL(1), .CHECK_CYCLES(1000000), .MAX_OUT(100),
                  .SEED(64'h7A5C_0000_0ACE_0001)) u1 (
      .clk(clk), .rst_n(rst_n), .req_valid(v1), .req_ready(1'b1), .req_addr(a1),
      .req_write(w1), .req_data(d1), .req_uncache(uc1), .cpl_valid(cv1),
      .cpl_addr(ca1), .err_stall(es1), .err_overflow(eo1));

   int errs = 0;
   int checks = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errs++;
         $display("FAIL %s actual=%0h expected=%0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   bit          out0 [logic [23:0]];
   bit          out1 [logic [23:0]];
   int unsigned last_acc = 0;
   bit          have_acc = 1'b0;
   int          nrd = 0, nwr = 0;
   int          n1 = 0;
   logic [23:0] last1 = '0;

   // second instance: ready is tied high, so each valid cycle is a new request
   always @(negedge clk) begin
      if (rst_n && v1) begin
         chk(!out1.exists(a1), "R7 u1 duplicate outstanding address", a1, 0);
         chk(!w1, "R4 u1 read-only mix", w1, 0);
         chk(!uc1 && (a1[23:20] == 4'h1 || a1[23:20] == 4'h4), "R3 u1 cacheable window", a1[23:20], 1);
         chk(a1[1:0] == 2'd3 && a1[19:4] == '0, "R2 u1 id lane and offset range", a1, 24'h100003);
         out1[a1] = 1'b1;
         n1++;
         last1 = a1;
      end
   end

   task automatic take0(input int hold, output logic [23:0] adr);
      logic [23:0] sa;
      logic [7:0]  sd;
      logic        sw, su;
      while (!v0) @(negedge clk);
      if (have_acc) chk(cyc - last_acc >= I0, "R6 issue gap after acceptance", cyc - last_acc, I0);
      chk(a0[5:0] == 6'd5 && a0[19:12] == '0, "R2 id lane and offset range", a0, 5);
      chk((a0[23:20] == 4'h8) == uc0 &&
          (a0[23:20] == 4'h1 || a0[23:20] == 4'h4 || a0[23:20] == 4'h8),
          "R3 window matches uncacheable flag", {a0[23:20], 3'b0, uc0}, 0);
      chk(!out0.exists(a0), "R7 address already outstanding", a0, 0);
      if (w0) nwr++; else nrd++;
      sa = a0; sd = d0; sw = w0; su = uc0;
      for (int k = 0; k < hold; k++) begin
         @(negedge clk);
         chk(v0 && a0 == sa && d0 == sd && w0 == sw && uc0 == su,
             "R5 request held under backpressure", {v0, a0}, {1'b1, sa});
      end
      r0 = 1'b1;
      @(negedge clk);
      r0 = 1'b0;
      last_acc = cyc;
      have_acc = 1'b1;
      out0[sa] = 1'b1;
      adr = sa;
   endtask

   task automatic done0(input logic [23:0] adr);
      cv0 = 1'b1; ca0 = adr;
      @(negedge clk);
      cv0 = 1'b0;
      out0.delete(adr);
   endtask

   initial begin
      logic [23:0] a;
      logic [23:0] pend [$];
      repeat (3) @(negedge clk);
      chk(!v0 && !es0 && !eo0, "R1 outputs idle in reset", {v0, es0, eo0}, 0);
      chk(!v1, "R1 u1 valid idle in reset", v1, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(v0, "R1 first request one edge after reset", v0, 1);

      for (int i = 0; i < NV; i++) begin
         take0(int'(VEC[i][4:1]), a);
         if (VEC[i][0]) done0(a);
         else pend.push_back(a);
      end
      while (pend.size() > 0) done0(pend.pop_front());
      chk(nrd > 0 && nwr > 0, "R4 mixed read and write commands", {nrd, nwr}, 1);
      chk(!eo0, "R10 no overflow while under limit", eo0, 0);
      chk(!es0, "R9 no stall flag while traffic flows", es0, 0);

      // overflow boundary: MAX_OUT outstanding is allowed, one more is not
      for (int i = 0; i < M0; i++) take0(0, a);
      @(negedge clk);
      chk(!eo0, "R10 exactly MAX_OUT outstanding", eo0, 0);
      take0(0, a);
      chk(!eo0, "R10 flag one edge after count exceeds", eo0, 0);
      @(negedge clk);
      chk(eo0, "R10 overflow flagged", eo0, 1);

      // stall watchdog boundary relative to the last acceptance
      while (cyc < last_acc + C0 - 1) @(negedge clk);
      chk(!es0, "R9 stall flag not before CHECK_CYCLES edges", es0, 0);
      @(negedge clk);
      chk(es0, "R9 stall flag at CHECK_CYCLES edges", es0, 1);
      repeat (5) @(negedge clk);
      chk(es0 && eo0, "R9 R10 flags sticky", {es0, eo0}, 3);

      // second instance: all eight reachable addresses are now in flight
      chk(n1 == 8, "R7 issue stops when every address is outstanding", n1, 8);
      cv1 = 1'b1; ca1 = 24'h100003;
      @(negedge clk);
      cv1 = 1'b0;
      out1.delete(24'h100003);
      repeat (60) @(negedge clk);
      chk(n1 == 9 && last1 == 24'h100003, "R8 completion frees the address", last1, 24'h100003);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      #(4 * 100000);
      if (!done) begin
         errs++;
         checks++;
         $display("FAIL watchdog expired: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errs, checks);
         $finish;
      end
   end

endmodule